// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the slave side of a two-wire serial memory. It holds 1024 bytes. A system clock oversamples the clock line and the data line, so the block spots start and stop conditions and shifts bytes in and out on the bus clock edges. It drives the data line only through an open-drain enable: when `sda_oe` is 1 the line is pulled low.

A master opens a transaction with a start and sends a device byte. Bits [7:3] must equal bits [6:2] of the `DEV_ID` parameter. Bits [2:1] carry word-address bits [9:8], and bit 0 selects the direction (0 = write, 1 = read). On a write, the next byte gives word-address bits [7:0]. Data bytes after that are collected in a 16-byte page buffer. A stop that follows at least one complete data byte starts a self-timed write cycle of `WRITE_CYCLES` system clocks. At the end of that cycle the buffered page is committed to the store. On a read, bytes stream out from the internal address counter for as long as the master acknowledges them.

The controller is a single state machine with these states:
- `ST_IDLE`
- `ST_DEV` (device byte)
- `ST_DEV_ACK`
- `ST_WADR` (word address)
- `ST_WADR_ACK`
- `ST_WDAT` (write data)
- `ST_WDAT_ACK`
- `ST_RDAT` (read data)
- `ST_RACK` (master acknowledge)
- `ST_SKIP` (not addressed or read ended; waits for a start or a stop)
- `ST_BUSY` (write cycle)

Its transitions are these:
- A start leaves any state except `ST_BUSY` for `ST_DEV`.
- A stop goes to `ST_BUSY` when it closes a write with buffered data, and to `ST_IDLE` otherwise.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match and to `ST_SKIP` on a mismatch.
- Each byte state goes to its acknowledge state after eight bits.
- Each acknowledge state returns to the byte stream on the next SCL fall.
- `ST_RACK` goes back to `ST_RDAT` on a master acknowledge and to `ST_SKIP` on a not-acknowledge.
- `ST_BUSY` goes to `ST_IDLE` when the timer expires.

Top module: `ee2w_slave`

## Requirements
- R1: After reset the block is idle and releases the data line (`sda_oe` = 0).
- R2: A device byte sent without a preceding start is not acknowledged. After a start, a matching device byte is acknowledged: SDA is held low from the SCL fall after the eighth bit until the SCL fall that ends the ninth pulse.
- R3: A device byte whose bits [7:3] differ from `DEV_ID[6:2]` gets no acknowledge, and the bytes after it get none until the next start.
- R4: On a write, the byte after the device byte sets word-address bits [7:0], with bits [9:8] taken from device-byte bits [2:1]. Each whole data byte is acknowledged and ends up stored at the current address.
- R5: After each data byte of a write, address bits [3:0] increment modulo 16 while bits [9:4] stay fixed. More than sixteen bytes therefore overwrite bytes written earlier in the same transaction.
- R6: The write cycle starts at the stop and lasts `WRITE_CYCLES` system clocks. The page is committed only at its end.
- R7: While the write cycle runs, all bus input is ignored. An addressed start gets no acknowledge, and a full write sent in that window changes nothing. Once the cycle is over, a device byte is acknowledged again.
- R8: Read data comes from the address counter, MSB first. Each bit changes after an SCL fall. The 10-bit counter increments after each byte. A master acknowledge (SDA low in the ninth pulse) continues the stream; a not-acknowledge releases SDA and ends read output.
- R9: A start or stop that arrives after two or more bits of a byte aborts the transaction. Buffered write data is discarded and no write cycle starts.
- R10: `sda_oe` changes only while SCL is low, except in the cycle right after a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain enable) |

## Verification
Two functions can fall in the same cycle: the bus front end decoding a start while the write-cycle timer is still counting, and the timer expiry committing the page.

The bench provokes this overlap in two ways. It sends address polls right after a stop and again just before the cycle ends. It also sends a complete write transaction to a neighbouring byte while the page commit is pending.

Both are judged at the ports. Polls must get no acknowledge until the window closes and must be acknowledged after it. A later sequential read must show the page with its wrapped overwrites and the neighbouring byte unchanged.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP,
        ST_BUSY
    } ee_state_e;

endpackage

// File: rtl/ee2w_line_cond.sv
module ee2w_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_sy, sda_sy;
    logic       scl_d, sda_d;

    // two-flop synchronizers plus one delayed copy for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_pin};
            sda_sy <= {sda_sy[0], sda_pin};
            scl_d  <= scl_sy[1];
            sda_d  <= sda_sy[1];
        end
    end

    assign scl_lvl  = scl_sy[1];
    assign sda_lvl  = sda_sy[1];
    assign scl_rise = scl_lvl & ~scl_d;
    assign scl_fall = ~scl_lvl & scl_d;
    assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/ee2w_page_buf.sv
module ee2w_page_buf #(
    parameter int BYTES = 16,
    parameter int OFF_W = $clog2(BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      wr_off,
    input  logic [7:0]            wr_byte,
    output logic [BYTES-1:0][7:0] page_q,
    output logic [BYTES-1:0]      valid_q
);
    logic [BYTES-1:0] hit;

    for (genvar g = 0; g < BYTES; g++) begin : g_slot
        assign hit[g] = wr_en && (wr_off == OFF_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= '0;
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                if (hit[i]) begin
                    page_q[i]  <= wr_byte;
                    valid_q[i] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
    parameter int DEPTH = 1024,
    parameter int BYTES = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int OFF_W = $clog2(BYTES),
    parameter int PG_W = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  commit,
    input  logic [PG_W-1:0]       commit_page,
    input  logic [BYTES-1:0][7:0] page_q,
    input  logic [BYTES-1:0]      valid_q,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_byte
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < BYTES; i++) begin
                if (valid_q[i]) mem[{commit_page, i[OFF_W-1:0]}] <= page_q[i];
            end
        end
    end

    assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/ee2w_wr_timer.sv
module ee2w_wr_timer #(
    parameter int CYCLES = 2000,
    parameter int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (go)         cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int          DEPTH        = 1024,
    parameter int          PAGE_BYTES   = 16,
    parameter logic [6:0]  DEV_ID       = 7'h50,
    parameter int          WRITE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - OFF_W;
    localparam int HI_W   = ADDR_W - 8;
    localparam int TAG_W  = 7 - HI_W;

    ee_state_e state, state_nx;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg, txreg, rd_byte;
    logic [ADDR_W-1:0] addr;
    logic              rw_lat, master_nack, have_data;
    logic              byte_done, dev_hit, receiving, counting;
    logic              pb_wr, pb_clr, commit, tmr_go, tmr_busy, tmr_done;
    logic [PAGE_BYTES-1:0][7:0] page_q;
    logic [PAGE_BYTES-1:0]      valid_q;

    ee2w_line_cond u_line (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_in), .sda_pin(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    ee2w_page_buf #(.BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr_en(pb_wr),
        .wr_off(addr[OFF_W-1:0]), .wr_byte(shreg),
        .page_q(page_q), .valid_q(valid_q)
    );

    ee2w_store #(.DEPTH(DEPTH), .BYTES(PAGE_BYTES), .ADDR_W(ADDR_W),
                 .OFF_W(OFF_W), .PG_W(PG_W)) u_store (
        .clk(clk), .commit(commit), .commit_page(addr[ADDR_W-1:OFF_W]),
        .page_q(page_q), .valid_q(valid_q), .rd_addr(addr), .rd_byte(rd_byte)
    );

    ee2w_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(tmr_go), .busy(tmr_busy), .done(tmr_done)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign dev_hit   = (shreg[7 -: TAG_W] == DEV_ID[6 -: TAG_W]);
    assign receiving = (state == ST_DEV) || (state == ST_WADR) || (state == ST_WDAT);
    assign counting  = receiving || (state == ST_RDAT);
    assign pb_wr     = (state == ST_WDAT) && byte_done;
    assign commit    = (state == ST_BUSY) && tmr_done;
    assign tmr_go    = (state != ST_BUSY) && (state_nx == ST_BUSY);
    assign pb_clr    = ((state != ST_BUSY) && (start_ev || stop_ev) && (state_nx != ST_BUSY))
                     || commit;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (state == ST_BUSY) begin
            if (tmr_done) state_nx = ST_IDLE;
        end else if (start_ev) begin
            state_nx = ST_DEV;
        end else if (stop_ev) begin
            // a clean stop sits at most one bit into the byte after an acknowledge
            state_nx = (state == ST_WDAT && bitcnt <= 4'd1 && have_data) ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP, ST_BUSY: ;
                ST_DEV:      if (byte_done) state_nx = dev_hit ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  if (scl_fall)  state_nx = rw_lat ? ST_RDAT : ST_WADR;
                ST_WADR:     if (byte_done) state_nx = ST_WADR_ACK;
                ST_WADR_ACK: if (scl_fall)  state_nx = ST_WDAT;
                ST_WDAT:     if (byte_done) state_nx = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall)  state_nx = ST_WDAT;
                ST_RDAT:     if (byte_done) state_nx = ST_RACK;
                ST_RACK:     if (scl_fall)  state_nx = master_nack ? ST_SKIP : ST_RDAT;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt      <= '0;
            shreg       <= '0;
            txreg       <= '1;
            addr        <= '0;
            rw_lat      <= 1'b0;
            master_nack <= 1'b0;
            have_data   <= 1'b0;
        end else begin
            if (state_nx != state || start_ev)  bitcnt <= '0;
            else if (scl_rise && counting)      bitcnt <= bitcnt + 1'b1;

            if (scl_rise && receiving) shreg <= {shreg[6:0], sda_lvl};

            if (state == ST_DEV && byte_done && dev_hit) begin
                rw_lat <= shreg[0];
                if (!shreg[0]) addr[ADDR_W-1:8] <= shreg[HI_W:1];
            end

            if (state == ST_WADR && byte_done) addr[7:0] <= shreg;

            if (pb_wr) begin
                addr[OFF_W-1:0] <= addr[OFF_W-1:0] + 1'b1;
                have_data       <= 1'b1;
            end else if (pb_clr) begin
                have_data <= 1'b0;
            end

            if (state_nx == ST_RDAT && state != ST_RDAT) begin
                txreg <= rd_byte;
                addr  <= addr + 1'b1;
            end else if (state == ST_RDAT && scl_fall && bitcnt != 4'd8) begin
                txreg <= {txreg[6:0], 1'b1};
            end

            if (state == ST_RACK && scl_rise) master_nack <= sda_lvl;
        end
    end

    // output logic
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT:                              sda_oe = ~txreg[7];
            default:                              sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk
    import ee2w_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              sda_oe,
    input logic              tmr_busy,
    input ee_state_e         state,
    input logic [ADDR_W-1:0] addr
);
    // R7: no acknowledge while the write cycle runs
    assert_busy_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !sda_oe);

    // R10: output only moves with SCL low, except right after start/stop
    assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

    // R2: a start outside the write cycle re-arms the device byte
    assert_start_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && state != ST_BUSY) |=> state == ST_DEV);

    // R5: upper address bits fixed across a data byte
    assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDAT_ACK && $past(state) == ST_WDAT)
        |-> addr[ADDR_W-1:OFF_W] == $past(addr[ADDR_W-1:OFF_W]));

    // R6: the busy state is always backed by a running timer
    assert_busy_timed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BUSY |-> tmr_busy);
endmodule

bind ee2w_slave ee2w_slave_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_oe(sda_oe), .tmr_busy(tmr_busy),
    .state(state), .addr(addr)
);

// File: tb/ee2w_slave_test.sv
module ee2w_slave_test;
    localparam int WC = 1000;
    localparam int Q  = 8;
    localparam logic [4:0] TAG = 5'b10100;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    int   n_chk = 0, n_bad = 0;
    bit   done_flag = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    ee2w_slave #(.WRITE_CYCLES(WC), .DEV_ID(7'h50)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] hi, input logic rd);
        return {TAG, hi, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; idle(Q); scl_m = 1'b1; idle(Q);
        sda_m = 1'b0; idle(Q); scl_m = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(Q); scl_m = 1'b1; idle(Q);
        sda_m = 1'b1; idle(Q);
    endtask

    task automatic clock_bit(input logic v);
        sda_m = v; idle(Q); scl_m = 1'b1; idle(2 * Q); scl_m = 1'b0; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        sda_m = 1'b1; idle(Q); scl_m = 1'b1; idle(Q);
        ack = ~sda_line;
        idle(Q); scl_m = 1'b0; idle(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit steady);
        steady = 1'b1; sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            idle(Q); scl_m = 1'b1; idle(Q);
            b[i] = sda_line;
            idle(Q);
            if (sda_line != b[i]) steady = 1'b0;
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        idle(Q); scl_m = 1'b1; idle(2 * Q); scl_m = 1'b0; idle(Q);
        sda_m = 1'b1;
    endtask

    // dummy write of the address followed by a repeated start for reading
    task automatic set_read_addr(input logic [9:0] a, input string req);
        bit ack;
        bus_start();
        send_byte(dev(a[9:8], 1'b0), ack); check(ack, req, ack, 1);
        send_byte(a[7:0], ack);            check(ack, req, ack, 1);
        bus_start();
        send_byte(dev(2'b00, 1'b1), ack);  check(ack, req, ack, 1);
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R1 idle release", sda_oe, 0);
    endtask

    task automatic t_no_start();
        bit ack;
        scl_m = 1'b0; idle(Q);
        send_byte(dev(2'b00, 1'b0), ack);
        check(!ack, "R2 no start", ack, 0);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        bit ack;
        bus_start();
        send_byte(8'b1011_0010, ack); check(!ack, "R3 mismatch", ack, 0);
        send_byte(dev(2'b00, 1'b0), ack); check(!ack, "R3 stays deaf", ack, 0);
        bus_stop();
    endtask

    task automatic t_byte_write();
        bit ack, st;
        logic [7:0] b;
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack); check(ack, "R2 dev ack", ack, 1);
        send_byte(8'h23, ack);            check(ack, "R4 word ack", ack, 1);
        send_byte(8'hA5, ack);            check(ack, "R4 data ack", ack, 1);
        bus_stop();
        bus_start();
        send_byte(dev(2'b00, 1'b0), ack); check(!ack, "R7 poll busy", ack, 0);
        bus_stop();
        idle(264);
        bus_start();
        send_byte(dev(2'b00, 1'b0), ack); check(!ack, "R6 not early", ack, 0);
        bus_stop();
        idle(200);
        set_read_addr(10'h123, "R6 ack after cycle");
        recv_byte(1'b0, b, st);
        check(b == 8'hA5, "R4 readback", b, 8'hA5);
        check(st, "R10 steady", st, 1);
        check(sda_oe == 1'b0, "R8 nack release", sda_oe, 0);
        bus_stop();
        bus_start();
        send_byte(dev(2'b10, 1'b0), ack);
        send_byte(8'h30, ack);
        send_byte(8'h77, ack); check(ack, "R4 second write", ack, 1);
        bus_stop();
        idle(WC + 100);
    endtask

    task automatic t_page_wrap();
        bit ack, st;
        int acks = 0;
        logic [7:0] b, e;
        bus_start();
        send_byte(dev(2'b10, 1'b0), ack);
        send_byte(8'h2E, ack);
        for (int k = 0; k < 18; k++) begin
            send_byte(8'h40 + 8'(k), ack);
            if (ack) acks++;
        end
        check(acks == 18, "R5 all acked", acks, 18);
        bus_stop();
        idle(50);
        bus_start();
        send_byte(dev(2'b10, 1'b0), ack); check(!ack, "R7 write ignored", ack, 0);
        send_byte(8'h30, ack);
        send_byte(8'h99, ack);
        bus_stop();
        idle(WC + 100);
        set_read_addr(10'h220, "R8 read setup");
        for (int o = 0; o < 17; o++) begin
            recv_byte(o != 16, b, st);
            if (o < 14)       e = 8'h42 + 8'(o);
            else if (o == 14) e = 8'h50;
            else if (o == 15) e = 8'h51;
            else              e = 8'h77;
            check(b == e, (o == 16) ? "R7 neighbour kept" : "R5 page wrap", b, e);
            check(st, "R10 steady", st, 1);
        end
        check(sda_oe == 1'b0, "R8 nack ends", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_abort();
        bit ack, st;
        logic [7:0] b;
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack);
        send_byte(8'h23, ack);
        send_byte(8'h3C, ack); check(ack, "R9 byte acked", ack, 1);
        clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1);
        bus_stop();
        set_read_addr(10'h123, "R9 no write cycle");
        recv_byte(1'b0, b, st);
        check(b == 8'hA5, "R9 data discarded", b, 8'hA5);
        bus_stop();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_no_start();
        t_wrong_addr();
        t_byte_write();
        t_page_wrap();
        t_abort();
        finish_run();
    end
endmodule